// File: doc/BRIEF.md
# Serial Character Transmitter with Fixed-Level Parity Option

This block turns a parallel data word into one asynchronous serial character on a single line. A character opens with a low start bit. The data bits follow, least significant first. An optional parity bit comes next, and one or two high stop bits close the character. The word length can be five to eight bits. The parity bit can be true odd parity or true even parity. It can also be held at a constant level, which is set by the even-select bit.

The data word, the frame settings and the parity bit are all captured when a character is loaded. Changes to the settings during a character do not affect it. An external baud tick, one pulse per bit period, moves the character out one bit at a time. A break control pulls the line low while it is set. The shifter keeps stepping underneath during a break, so the bits of a character that continue after the break lifts are the right ones.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no character is in progress, `txd` is 1 and `busy` is 0. Baud ticks while idle leave `txd` at 1.
- R2: The first bit period of a character is the start bit at 0. The data bits follow least significant first. `wlen` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Input bits above the selected length are not sent.
- R3: With `par_en`=1, `stick`=0 and `even_sel`=0, a parity bit follows the last data bit. The sent data bits plus the parity bit hold an odd number of ones.
- R4: With `par_en`=1, `stick`=0 and `even_sel`=1, the sent data bits plus the parity bit hold an even number of ones.
- R5: With `par_en`=1 and `stick`=1, the parity bit is the inverse of `even_sel`, whatever the data.
- R6: With `par_en`=0, no parity bit is sent, and `even_sel` and `stick` have no effect. The stop bits follow the last data bit at once.
- R7: The stop bits are 1. There is one stop bit when `stop2`=0 and two when `stop2`=1.
- R8: While `brk` is 1, `txd` is 0 in the same cycle. The shifter still steps on each tick, so after `brk` returns to 0, `txd` shows the bit that is due at that point of the character.
- R9: `busy` rises in the cycle after a `load` is accepted while idle. After the load, the first tick starts the start bit, and each tick after that starts the next bit. The tick that ends the last stop bit period clears `busy`.
- R10: A `load` pulse while `busy` is 1 is ignored. The character in progress continues unchanged.
- R11: `txd` changes only on a clock edge where `baud_tick` is 1, or when `brk` changes. Each bit lasts one full tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Strobe that accepts `din` and the settings while idle |
| din | input | 8 | Data word to send |
| wlen | input | 2 | Data bit count minus five |
| stop2 | input | 1 | 1 selects two stop bits |
| par_en | input | 1 | 1 inserts a parity bit |
| even_sel | input | 1 | Selects even parity, or sets the fixed parity level |
| stick | input | 1 | 1 holds the parity bit at the inverse of `even_sel` |
| brk | input | 1 | 1 forces the line to the low level |
| baud_tick | input | 1 | One pulse per bit period |
| txd | output | 1 | Serial line |
| busy | output | 1 | A character is in progress |

## Verification
A wrong bit count shows at the ports as a `busy` that falls one tick too early or one tick too late. A wrong parity or mask choice shows as a wrong level in the parity slot or in a data slot. Both are visible within a single character, at the tick that starts the slot concerned. A shifter that stalled during a break shows in the first bit after `brk` is released, because that bit would then be stale. A reload accepted while busy would corrupt the next sampled bit of the character in progress.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned WORD_MAX  = 8;
  localparam int unsigned FRAME_MAX = WORD_MAX + 4;
  localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1);

  function automatic int unsigned word_len(input logic [1:0] wlen);
    return 5 + 32'(wlen);
  endfunction

  function automatic logic [WORD_MAX-1:0] mask_word(input logic [WORD_MAX-1:0] data,
                                                    input logic [1:0] wlen);
    logic [WORD_MAX-1:0] m;
    for (int i = 0; i < WORD_MAX; i++) m[i] = data[i] && (i < int'(word_len(wlen)));
    return m;
  endfunction

  function automatic logic parity_of(input logic [WORD_MAX-1:0] masked,
                                     input logic even_sel, input logic stick);
    if (stick) return ~even_sel;
    return even_sel ? ^masked : ~^masked;
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(input logic [1:0] wlen,
                                                 input logic par_en, input logic stop2);
    return CNT_W'(2 + word_len(wlen) + 32'(par_en) + 32'(stop2));
  endfunction

  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [WORD_MAX-1:0] masked,
                                                       input logic [1:0] wlen,
                                                       input logic par_en, input logic par);
    logic [FRAME_MAX-1:0] f;
    int unsigned len;
    len  = word_len(wlen);
    f    = '1;
    f[0] = 1'b0;
    for (int i = 0; i < WORD_MAX; i++) if (i < int'(len)) f[i+1] = masked[i];
    if (par_en) f[len+1] = par;
    return f;
  endfunction
endpackage

// File: rtl/tx_parity.sv
module tx_parity
  import uart_tx_pkg::*;
(
  input  logic [WORD_MAX-1:0] data,
  input  logic [1:0]          wlen,
  input  logic                even_sel,
  input  logic                stick,
  output logic [WORD_MAX-1:0] masked,
  output logic                par_bit
);
  assign masked  = mask_word(data, wlen);
  assign par_bit = parity_of(masked, even_sel, stick);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import uart_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 baud_tick,
  input  logic [FRAME_MAX-1:0] frame_in,
  input  logic [CNT_W-1:0]     nbits_in,
  output logic                 line,
  output logic                 busy
);
  logic [FRAME_MAX-1:0] shreg;
  logic [CNT_W-1:0]     cnt;
  logic load_acc, bit_step, frame_done;

  assign load_acc   = load && !busy;
  assign bit_step   = baud_tick && busy && (cnt != '0);
  assign frame_done = baud_tick && busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      cnt   <= '0;
      busy  <= 1'b0;
      line  <= 1'b1;
    end else if (load_acc) begin
      shreg <= frame_in;
      cnt   <= nbits_in;
      busy  <= 1'b1;
      line  <= 1'b1;
    end else if (bit_step) begin
      line  <= shreg[0];
      shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
      cnt   <= cnt - 1'b1;
    end else if (frame_done) begin
      busy  <= 1'b0;
      line  <= 1'b1;
    end
  end

  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> line);
  a_r9_busy_rise: assert property (@(posedge clk) disable iff (!rst_n) load_acc |=> busy);
  a_r9_busy_fall: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> !busy);
  a_r10_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy && !baud_tick) |=> ($stable(cnt) && $stable(shreg)));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick) |=> $stable(line));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [WORD_MAX-1:0] din,
  input  logic [1:0]          wlen,
  input  logic                stop2,
  input  logic                par_en,
  input  logic                even_sel,
  input  logic                stick,
  input  logic                brk,
  input  logic                baud_tick,
  output logic                txd,
  output logic                busy
);
  logic [WORD_MAX-1:0]  masked;
  logic                 par_bit;
  logic [FRAME_MAX-1:0] frame;
  logic [CNT_W-1:0]     nbits;
  logic                 line;

  tx_parity u_par (
    .data(din), .wlen(wlen), .even_sel(even_sel), .stick(stick),
    .masked(masked), .par_bit(par_bit)
  );

  assign frame = build_frame(masked, wlen, par_en, par_bit);
  assign nbits = frame_len(wlen, par_en, stop2);

  tx_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .load(load), .baud_tick(baud_tick),
    .frame_in(frame), .nbits_in(nbits), .line(line), .busy(busy)
  );

  assign txd = line && !brk;

  a_r3_odd_total: assert property (@(posedge clk) disable iff (!rst_n)
    (par_en && !stick && !even_sel) |-> ($countones({masked, par_bit}) % 2 == 1));
  a_r4_even_total: assert property (@(posedge clk) disable iff (!rst_n)
    (par_en && !stick && even_sel) |-> ($countones({masked, par_bit}) % 2 == 0));
  a_r5_fixed_level: assert property (@(posedge clk) disable iff (!rst_n)
    (par_en && stick) |-> (par_bit != even_sel));
  a_r8_break_space: assert property (@(posedge clk) disable iff (!rst_n) brk |-> !txd);
endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, stop2 = 1'b0, par_en = 1'b0;
  logic even_sel = 1'b0, stick = 1'b0, brk = 1'b0, baud_tick = 1'b0;
  logic [7:0] din = 8'h00;
  logic [1:0] wlen = 2'd0;
  logic txd, busy;
  int n_chk = 0, n_bad = 0;

  uart_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .load(load), .din(din), .wlen(wlen), .stop2(stop2),
    .par_en(par_en), .even_sel(even_sel), .stick(stick), .brk(brk),
    .baud_tick(baud_tick), .txd(txd), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  function automatic logic exp_par(input logic [7:0] d, input int len,
                                   input logic es, input logic st);
    int ones = 0;
    for (int i = 0; i < len; i++) if (d[i]) ones++;
    if (st) return !es;
    if (es) return (ones % 2) == 1;
    return (ones % 2) == 0;
  endfunction

  function automatic logic exp_bit(input logic [7:0] d, input int len, input logic pe,
                                   input logic es, input logic st, input int idx);
    if (idx == 0) return 1'b0;
    if (idx <= len) return d[idx-1];
    if (pe && idx == len + 1) return exp_par(d, len, es, st);
    return 1'b1;
  endfunction

  task automatic tick();
    @(negedge clk) baud_tick = 1'b1;
    @(negedge clk) baud_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] wl, input logic s2,
                      input logic pe, input logic es, input logic st,
                      input logic [11:0] brk_mask, input int reload_at, input string tag);
    int len = 5 + int'(wl);
    int n = 2 + len + int'(pe) + int'(s2);
    @(negedge clk);
    din = d; wlen = wl; stop2 = s2; par_en = pe; even_sel = es; stick = st; load = 1'b1;
    @(negedge clk) load = 1'b0;
    din = ~d; wlen = ~wl; par_en = ~pe; even_sel = ~es; stick = ~st; stop2 = ~s2;
    chk({"R9 busy after load ", tag}, busy, 1'b1);
    chk({"R9 line high before first tick ", tag}, txd, 1'b1);
    for (int i = 0; i < n; i++) begin
      brk = brk_mask[i];
      tick();
      if (i == reload_at) begin
        load = 1'b1;
        @(negedge clk) load = 1'b0;
      end
      chk({(brk_mask[i] ? "R8 " : (i == 0) ? "R2 " :
           (i <= len) ? "R2 " : (pe && i == len + 1) ? "R3/R4/R5 " : "R7 "), tag},
          txd, brk_mask[i] ? 1'b0 : exp_bit(d, len, pe, es, st, i));
      repeat (2) @(negedge clk);
      chk({"R11 bit held ", tag}, txd, brk_mask[i] ? 1'b0 : exp_bit(d, len, pe, es, st, i));
    end
    brk = 1'b0;
    @(negedge clk);
    chk({"R9 busy through last stop ", tag}, busy, 1'b1);
    tick();
    chk({"R9 busy falls ", tag}, busy, 1'b0);
    chk({"R1 idle mark ", tag}, txd, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h5eed_0017;
    void'($urandom(seed));
    #(CLK_PERIOD * 2);
    chk("R1 reset txd", txd, 1'b1);
    chk("R1 reset busy", busy, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    tick();
    chk("R1 idle tick txd", txd, 1'b1);
    chk("R1 idle tick busy", busy, 1'b0);

    send(8'h07, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 12'h0, -1, "R3 odd");
    send(8'h07, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 12'h0, -1, "R4 even");
    send(8'h07, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 12'h0, -1, "R5 stick es1");
    send(8'h07, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 12'h0, -1, "R5 stick es0");
    send(8'hFF, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h0, -1, "R6 no parity");
    send(8'hE5, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 12'h0, -1, "R7 two stop");
    send(8'h5A, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 12'h01C, -1, "R8 break");
    send(8'h3C, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 12'h0, 3, "R10 reload");

    for (int k = 0; k < 40; k++) begin
      logic [7:0] d = 8'($urandom);
      logic [5:0] c = 6'($urandom);
      send(d, c[1:0], c[2], c[3], c[4], c[5], 12'h0, -1, "R2 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule